// File: doc/BRIEF.md
# Three-Bus 16-Bit Processor Datapath

This block is the data side of a small teaching processor. Two operand buses, A and B, feed an eight-function ALU, and the ALU result comes back on a third bus, C. Bus C is the only path into the four-entry register file and into the program counter, instruction register, memory address register and memory data register. A status register captures a negative flag and a zero flag from bus C.

Every bus source, the ALU function and every register load comes from a sequencing controller outside this block, one set of control inputs per clock. The memory array is also outside the block. It sees the address register and the data register at the ports, and it returns read data on `mem_rdata`. The B-side operand multiplexer can take its value from fields of the instruction word instead of a register. It offers a sign-extended 5-bit immediate, a sign-extended 9-bit branch offset, or a zero-extended 12-bit address. This lets a single ALU pass add immediates, compute branch targets and form direct addresses.

Top module: `dp16_core`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the PC, IR, MAR, MDR, both flags and all four registers become zero on that edge.
- R2: `bus_c` is combinational from the operands. `alu_op` selects the function: 0 gives A, 1 gives B, 2 gives A+B, 3 gives A−B, 4 gives A AND B, 5 gives A OR B, 6 gives A XOR B, and 7 gives NOT A. Sums and differences wrap modulo 2^16.
- R3: Register reads through `ra_sel` and `rb_sel` are combinational. When `rf_we` is high, the register `rw_sel` takes `bus_c` at the rising edge. A read of that same register in the write cycle returns the old contents.
- R4: When `ld_status` is high, the edge sets `flag_n` to `bus_c[15]` and sets `flag_z` to 1 exactly when `bus_c` is zero. When `ld_status` is low, both flags hold.
- R5: `a_src` selects bus A: 0 is register port `ra_sel`, 1 is the PC zero-extended to 16 bits, 2 is the MDR, 3 is zero.
- R6: `b_mode` selects the B operand: 0 is register port `rb_sel`, 1 is IR[4:0] sign-extended, 2 is IR[8:0] sign-extended, 3 is IR[11:0] zero-extended.
- R7: When `ld_pc` is high, the PC loads `bus_c[11:0]`. When only `inc_pc` is high, the PC increments and wraps from 0xFFF to 0. `ld_pc` wins when both are high.
- R8: `ld_ir` loads the whole `bus_c` into the IR. `ld_mar` loads `bus_c[11:0]` into the MAR.
- R9: `ld_mdr` loads the MDR from `mem_rdata` when `mdr_src` is 1, and from `bus_c` when it is 0.
- R10: A register whose load or write enable is low keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ra_sel | input | 2 | Register read address for bus A |
| rb_sel | input | 2 | Register read address for bus B |
| rw_sel | input | 2 | Register write address |
| rf_we | input | 1 | Register file write enable |
| a_src | input | 2 | Bus A source select |
| b_mode | input | 2 | B operand select (register or instruction field) |
| alu_op | input | 3 | ALU function code |
| ld_status | input | 1 | Load N and Z flags from bus C |
| ld_pc | input | 1 | Load PC from bus C |
| inc_pc | input | 1 | Increment PC |
| ld_ir | input | 1 | Load IR from bus C |
| ld_mar | input | 1 | Load MAR from bus C |
| ld_mdr | input | 1 | Load MDR |
| mdr_src | input | 1 | MDR source: 1 memory read data, 0 bus C |
| mem_rdata | input | 16 | Data returned by memory |
| bus_c | output | 16 | ALU result bus |
| pc | output | 12 | Program counter |
| ir | output | 16 | Instruction register |
| mar | output | 12 | Memory address register |
| mdr | output | 16 | Memory data register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
A wrong value in a register-file entry stays hidden until a later cycle routes that entry onto bus A or B. The bench therefore steers reads through every entry and compares `bus_c` in the same cycle. PC, IR, MAR, MDR and the flags are ports, so a bad load, a missed hold or a wrong increment shows one edge after the cycle that caused it. A wrong operand extension or ALU code shows on `bus_c` in the cycle it is driven, with no latency at all.

// File: rtl/dp16_pkg.sv
// Shared encodings for the three-bus datapath.
// Assumes: select fields arrive as plain vectors and are cast to these types.
package dp16_pkg;

    typedef enum logic [2:0] {
        ALU_PASS_A = 3'd0,
        ALU_PASS_B = 3'd1,
        ALU_ADD    = 3'd2,
        ALU_SUB    = 3'd3,
        ALU_AND    = 3'd4,
        ALU_OR     = 3'd5,
        ALU_XOR    = 3'd6,
        ALU_NOT_A  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        ASRC_REG  = 2'd0,
        ASRC_PC   = 2'd1,
        ASRC_MDR  = 2'd2,
        ASRC_ZERO = 2'd3
    } a_src_e;

    typedef enum logic [1:0] {
        BMODE_REG   = 2'd0,
        BMODE_IMM   = 2'd1,
        BMODE_OFS   = 2'd2,
        BMODE_ADDR  = 2'd3
    } b_mode_e;

endpackage

// File: rtl/dp16_regfile.sv
// Register file: NREG words, two combinational read ports, one write port.
// Assumes: the write lands on the rising edge, so a same-cycle read sees old data;
// synchronous active-low reset clears every entry.
module dp16_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rd_a_sel,
    input  logic [SW-1:0] rd_b_sel,
    input  logic [SW-1:0] wr_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);

    logic [DW-1:0] entry [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        // Purpose: one storage word, written when addressed and enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[g] <= '0;
            else if (wr_en && (wr_sel == SW'(g)))
                entry[g] <= wr_data;
        end
    end

    // Purpose: combinational read ports.
    always_comb begin
        rd_a = entry[rd_a_sel];
        rd_b = entry[rd_b_sel];
    end

endmodule

// File: rtl/dp16_bmux.sv
// B operand multiplexer: register data or an extended field of the instruction.
// Assumes: only the low AW instruction bits are needed; short fields are IW and OW bits.
module dp16_bmux #(
    parameter int DW = 16,
    parameter int AW = 12,
    parameter int IW = 5,
    parameter int OW = 9
) (
    input  logic [1:0]    mode,
    input  logic [DW-1:0] reg_val,
    input  logic [AW-1:0] ir_low,
    output logic [DW-1:0] operand
);
    import dp16_pkg::*;

    // Purpose: choose and extend the B operand.
    always_comb begin
        case (b_mode_e'(mode))
            BMODE_REG:  operand = reg_val;
            BMODE_IMM:  operand = {{(DW-IW){ir_low[IW-1]}}, ir_low[IW-1:0]};
            BMODE_OFS:  operand = {{(DW-OW){ir_low[OW-1]}}, ir_low[OW-1:0]};
            default:    operand = {{(DW-AW){1'b0}}, ir_low};
        endcase
    end

endmodule

// File: rtl/dp16_alu.sv
// Eight-function ALU; pure combinational, wraps on overflow.
// Assumes: codes follow dp16_pkg::alu_op_e.
module dp16_alu #(
    parameter int DW = 16
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    import dp16_pkg::*;

    // Purpose: compute the selected function.
    always_comb begin
        case (alu_op_e'(op))
            ALU_PASS_A: y = a;
            ALU_PASS_B: y = b;
            ALU_ADD:    y = a + b;
            ALU_SUB:    y = a - b;
            ALU_AND:    y = a & b;
            ALU_OR:     y = a | b;
            ALU_XOR:    y = a ^ b;
            default:    y = ~a;
        endcase
    end

endmodule

// File: rtl/dp16_core.sv
// Three-bus datapath top: buses A and B feed the ALU, bus C feeds every load.
// Assumes: an external controller drives all selects and loads each cycle;
// memory sits outside and is reached through mar, mdr and mem_rdata.
module dp16_core #(
    parameter int DW   = 16,
    parameter int AW   = 12,
    parameter int NREG = 4,
    parameter int IW   = 5,
    parameter int OW   = 9,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] ra_sel,
    input  logic [SW-1:0] rb_sel,
    input  logic [SW-1:0] rw_sel,
    input  logic          rf_we,
    input  logic [1:0]    a_src,
    input  logic [1:0]    b_mode,
    input  logic [2:0]    alu_op,
    input  logic          ld_status,
    input  logic          ld_pc,
    input  logic          inc_pc,
    input  logic          ld_ir,
    input  logic          ld_mar,
    input  logic          ld_mdr,
    input  logic          mdr_src,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] bus_c,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] ir,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mdr,
    output logic          flag_n,
    output logic          flag_z
);
    import dp16_pkg::*;

    localparam logic [AW-1:0] PC_STEP = AW'(1);

    logic [DW-1:0] rf_a, rf_b, bus_a, bus_b;

    dp16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_sel (ra_sel),
        .rd_b_sel (rb_sel),
        .wr_sel   (rw_sel),
        .wr_en    (rf_we),
        .wr_data  (bus_c),
        .rd_a     (rf_a),
        .rd_b     (rf_b)
    );

    // Purpose: bus A source selection.
    always_comb begin
        case (a_src_e'(a_src))
            ASRC_REG:  bus_a = rf_a;
            ASRC_PC:   bus_a = {{(DW-AW){1'b0}}, pc};
            ASRC_MDR:  bus_a = mdr;
            default:   bus_a = '0;
        endcase
    end

    dp16_bmux #(.DW(DW), .AW(AW), .IW(IW), .OW(OW)) u_bmux (
        .mode    (b_mode),
        .reg_val (rf_b),
        .ir_low  (ir[AW-1:0]),
        .operand (bus_b)
    );

    dp16_alu #(.DW(DW)) u_alu (
        .op (alu_op),
        .a  (bus_a),
        .b  (bus_b),
        .y  (bus_c)
    );

    // Purpose: program counter, load over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (ld_pc)  pc <= bus_c[AW-1:0];
        else if (inc_pc) pc <= pc + PC_STEP;
    end

    // Purpose: instruction and memory address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir  <= '0;
            mar <= '0;
        end else begin
            if (ld_ir)  ir  <= bus_c;
            if (ld_mar) mar <= bus_c[AW-1:0];
        end
    end

    // Purpose: memory data register from memory or bus C.
    always_ff @(posedge clk) begin
        if (!rst_n)      mdr <= '0;
        else if (ld_mdr) mdr <= mdr_src ? mem_rdata : bus_c;
    end

    // Purpose: negative and zero flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (ld_status) begin
            flag_n <= bus_c[DW-1];
            flag_z <= (bus_c == '0);
        end
    end

endmodule

// File: rtl/dp16_core_chk.sv
// Checker for dp16_core, bound to every instance.
// Assumes: the default widths (16-bit data, 12-bit addresses).
module dp16_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_status,
    input logic        ld_pc,
    input logic        inc_pc,
    input logic        ld_ir,
    input logic        ld_mar,
    input logic [15:0] bus_c,
    input logic [11:0] pc,
    input logic [15:0] ir,
    input logic [11:0] mar,
    input logic        flag_n,
    input logic        flag_z
);

    a_r4_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_status)) |->
            (flag_n == $past(bus_c[15]) && flag_z == ($past(bus_c) == 16'd0)));

    a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_status)) |-> ($stable(flag_n) && $stable(flag_z)));

    a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_pc) && $past(inc_pc)) |-> (pc == $past(pc) + 12'd1));

    a_r7_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_pc)) |-> (pc == $past(bus_c[11:0])));

    a_r8_mar_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_mar)) |-> (mar == $past(bus_c[11:0])));

    a_r10_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_ir)) |-> $stable(ir));

endmodule

bind dp16_core dp16_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_status (ld_status),
    .ld_pc     (ld_pc),
    .inc_pc    (inc_pc),
    .ld_ir     (ld_ir),
    .ld_mar    (ld_mar),
    .bus_c     (bus_c),
    .pc        (pc),
    .ir        (ir),
    .mar       (mar),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
);

// File: tb/tb_dp16_core.sv
// Bench: fixed-seed random control words plus directed corners, checked against
// a behavioural model kept in the bench and built from the requirements.
module tb_dp16_core;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] ra_sel, rb_sel, rw_sel, a_src, b_mode;
    logic [2:0] alu_op;
    logic rf_we, ld_status, ld_pc, inc_pc, ld_ir, ld_mar, ld_mdr, mdr_src;
    logic [15:0] mem_rdata, bus_c, ir, mdr;
    logic [11:0] pc, mar;
    logic flag_n, flag_z;

    int total = 0;
    int bad = 0;

    logic [15:0] m_reg [4];
    logic [15:0] m_ir, m_mdr;
    logic [11:0] m_pc, m_mar;
    logic m_n, m_z;

    always #2 clk = ~clk;

    dp16_core dut (
        .clk(clk), .rst_n(rst_n), .ra_sel(ra_sel), .rb_sel(rb_sel), .rw_sel(rw_sel),
        .rf_we(rf_we), .a_src(a_src), .b_mode(b_mode), .alu_op(alu_op),
        .ld_status(ld_status), .ld_pc(ld_pc), .inc_pc(inc_pc), .ld_ir(ld_ir),
        .ld_mar(ld_mar), .ld_mdr(ld_mdr), .mdr_src(mdr_src), .mem_rdata(mem_rdata),
        .bus_c(bus_c), .pc(pc), .ir(ir), .mar(mar), .mdr(mdr),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    function automatic logic [15:0] alu_f(logic [2:0] op, logic [15:0] a, logic [15:0] b);
        case (op)
            3'd0: return a;
            3'd1: return b;
            3'd2: return a + b;
            3'd3: return a - b;
            3'd4: return a & b;
            3'd5: return a | b;
            3'd6: return a ^ b;
            default: return ~a;
        endcase
    endfunction

    function automatic logic [15:0] exp_bus();
        logic [15:0] a, b;
        case (a_src)
            2'd0: a = m_reg[ra_sel];
            2'd1: a = {4'h0, m_pc};
            2'd2: a = m_mdr;
            default: a = 16'h0;
        endcase
        case (b_mode)
            2'd0: b = m_reg[rb_sel];
            2'd1: b = {{11{m_ir[4]}}, m_ir[4:0]};
            2'd2: b = {{7{m_ir[8]}}, m_ir[8:0]};
            default: b = {4'h0, m_ir[11:0]};
        endcase
        return alu_f(alu_op, a, b);
    endfunction

    task automatic check(input logic ok, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle();
        rf_we = 0; ld_status = 0; ld_pc = 0; inc_pc = 0; ld_ir = 0;
        ld_mar = 0; ld_mdr = 0; mdr_src = 0;
        ra_sel = 0; rb_sel = 0; rw_sel = 0; a_src = 0; b_mode = 0; alu_op = 0;
        mem_rdata = 16'h0;
    endtask

    // Check bus C mid-cycle, advance one edge, update the model, check registers.
    task automatic step(input string tag);
        logic [15:0] c;
        #1;
        c = exp_bus();
        if (rst_n) check(bus_c == c, tag, bus_c, c);
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_reg[i] = 16'h0;
            m_pc = 0; m_ir = 0; m_mar = 0; m_mdr = 0; m_n = 0; m_z = 0;
        end else begin
            if (rf_we) m_reg[rw_sel] = c;
            if (ld_ir) m_ir = c;
            if (ld_mar) m_mar = c[11:0];
            if (ld_mdr) m_mdr = mdr_src ? mem_rdata : c;
            if (ld_pc) m_pc = c[11:0];
            else if (inc_pc) m_pc = m_pc + 12'd1;
            if (ld_status) begin m_n = c[15]; m_z = (c == 16'h0); end
        end
        #1;
        check(pc == m_pc, "R1/R7/R10 pc", {4'h0, pc}, {4'h0, m_pc});
        check(ir == m_ir, "R1/R8/R10 ir", ir, m_ir);
        check(mar == m_mar, "R1/R8/R10 mar", {4'h0, mar}, {4'h0, m_mar});
        check(mdr == m_mdr, "R1/R9/R10 mdr", mdr, m_mdr);
        check(flag_n == m_n && flag_z == m_z, "R1/R4 flags",
              {14'h0, flag_n, flag_z}, {14'h0, m_n, m_z});
    endtask

    task automatic put_mdr(input logic [15:0] v);
        idle(); ld_mdr = 1; mdr_src = 1; mem_rdata = v;
        step("R9 mdr from memory");
    endtask

    task automatic put_reg(input logic [1:0] idx, input logic [15:0] v);
        put_mdr(v);
        idle(); a_src = 2'd2; alu_op = 3'd0; rw_sel = idx; rf_we = 1;
        step("R5 mdr onto bus A");
    endtask

    task automatic put_ir(input logic [15:0] v);
        put_mdr(v);
        idle(); a_src = 2'd2; alu_op = 3'd0; ld_ir = 1;
        step("R8 ir load");
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            idle(); ra_sel = 2'(i); a_src = 2'd0; alu_op = 3'd0;
            step(tag);
        end
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 4; i++) m_reg[i] = 16'h0;
        m_pc = 0; m_ir = 0; m_mar = 0; m_mdr = 0; m_n = 0; m_z = 0;
        idle();
        rst_n = 0;
        @(posedge clk); #1;
        // R1: reset overrides every load that is asserted with it
        rf_we = 1; ld_status = 1; ld_pc = 1; ld_ir = 1; ld_mar = 1; ld_mdr = 1;
        mdr_src = 1; mem_rdata = 16'hBEEF; inc_pc = 1;
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;
        read_all("R1 register cleared by reset");

        // R3: fill registers, then read back
        put_reg(2'd0, 16'h1234);
        put_reg(2'd1, 16'h8000);
        put_reg(2'd2, 16'h00FF);
        put_reg(2'd3, 16'hFFFF);
        read_all("R3 register readback");

        // R3: write and read of the same register in one cycle sees the old word
        put_mdr(16'h0010);
        idle(); a_src = 2'd2; b_mode = 2'd0; rb_sel = 2'd2; alu_op = 3'd2;
        rw_sel = 2'd2; rf_we = 1;
        step("R3 same-cycle read returns old value");
        read_all("R3 written value visible next cycle");

        // R4: zero and negative results captured
        idle(); ra_sel = 2'd1; rb_sel = 2'd1; alu_op = 3'd3; ld_status = 1;
        step("R4 zero result");
        idle(); ra_sel = 2'd1; alu_op = 3'd0; ld_status = 1;
        step("R4 negative result");
        idle(); ra_sel = 2'd0; alu_op = 3'd7;
        step("R4 flags hold with ld_status low");

        // R6: extension modes with IR = 0x0F1F
        put_ir(16'h0F1F);
        for (int m = 0; m < 4; m++) begin
            idle(); b_mode = 2'(m); rb_sel = 2'd0; alu_op = 3'd1;
            step("R6 B operand mode");
        end
        put_ir(16'h000F);
        for (int m = 1; m < 4; m++) begin
            idle(); b_mode = 2'(m); alu_op = 3'd1;
            step("R6 B operand positive field");
        end

        // R7: wrap, increment, load priority
        put_mdr(16'hAFFF);
        idle(); a_src = 2'd2; alu_op = 3'd0; ld_pc = 1;
        step("R7 pc load truncates");
        idle(); inc_pc = 1;
        step("R7 pc wraps to zero");
        idle(); inc_pc = 1;
        step("R7 pc increments");
        idle(); a_src = 2'd1; alu_op = 3'd0;
        step("R5 pc onto bus A");
        idle(); a_src = 2'd2; alu_op = 3'd0; ld_pc = 1; inc_pc = 1;
        step("R7 load wins over increment");

        // R8: MAR keeps low bits only
        put_mdr(16'hABCD);
        idle(); a_src = 2'd2; alu_op = 3'd0; ld_mar = 1;
        step("R8 mar load");

        // R9: MDR from bus C
        idle(); a_src = 2'd3; alu_op = 3'd7; ld_mdr = 1; mdr_src = 0; mem_rdata = 16'h5555;
        step("R5 zero source, R9 mdr from bus C");

        // R10: no enables, random operand traffic
        for (int k = 0; k < 6; k++) begin
            idle(); ra_sel = 2'($urandom); rb_sel = 2'($urandom); rw_sel = 2'($urandom);
            a_src = 2'($urandom); b_mode = 2'($urandom); alu_op = 3'($urandom);
            mem_rdata = 16'($urandom); mdr_src = 1'($urandom);
            step("R10 hold");
        end
        read_all("R10 registers held");

        // R2/R5/R6: random control words
        for (int k = 0; k < 600; k++) begin
            ra_sel = 2'($urandom); rb_sel = 2'($urandom); rw_sel = 2'($urandom);
            a_src = 2'($urandom); b_mode = 2'($urandom); alu_op = 3'($urandom);
            rf_we = 1'($urandom); ld_status = 1'($urandom); ld_pc = 1'($urandom % 4 == 0);
            inc_pc = 1'($urandom); ld_ir = 1'($urandom % 3 == 0); ld_mar = 1'($urandom);
            ld_mdr = 1'($urandom); mdr_src = 1'($urandom); mem_rdata = 16'($urandom);
            if (k % 50 == 7) mem_rdata = 16'h0;
            step("R2 random bus_c");
        end
        read_all("R3 final readback");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule